// File: doc/BRIEF.md
# Diode Emulation Mode Controller

This block sits between a ripple-based PWM modulator and the gate drivers of a synchronous buck stage. Every clock cycle it decides whether the low-side switch acts as a forced synchronous rectifier or as an emulated diode. A digital PWM request drives the high-side enable. The low-side enable fills the off-time. A one-clock dead cycle with both enables low separates every hand-over between the two switches.

When the mode-select input is low, the block watches the sign of the switch node. This sign is sampled once per low-side pulse, at a fixed clock offset after the low-side gate turns on, so ringing at turn-on is not seen. A run of consecutive positive samples shows reverse inductor current and moves the block into diode emulation. In emulation, a positive sample turns the low-side switch off for the rest of that off-time. A negative sample sends the block back to continuous conduction.

Diode emulation lowers the switching frequency. An idle counter therefore forces a high-side pulse whenever the high-side switch has stayed off for a programmable number of clocks. This keeps the frequency above the audible band.

Top module: `buck_dem_ctrl`

## Requirements
- R1: Outside emulation, whenever the high-side enable and the effective PWM request (request or forced pulse) were both low in the previous cycle, the low-side enable is high.
- R2: With mode-select low at the last high-side rising edge, emulation (status bit high) starts in the cycle after the RUN_LEN-th consecutive phase sample that reads positive (phase flag 1).
- R3: A phase sample that reads negative (phase flag 0) outside emulation clears the run, so the count restarts from zero.
- R4: In emulation, a positive phase sample drops the low-side enable in the next cycle, and it stays low until the next high-side pulse.
- R5: In emulation, a negative phase sample clears the status bit in the next cycle.
- R6: After CLAMP_US microseconds of clock ticks with the high-side enable low, the clamp request is high for exactly one cycle, and a high-side pulse follows even with the PWM request low.
- R7: Mode-select high clears emulation in the next cycle. Mode-select low allows entry only from the next high-side rising edge.
- R8: High-side and low-side enables are never high together, and each one rises only after a cycle in which the other was low.
- R9: The phase flag is used only on the (SAMPLE_DLY+1)-th cycle of a low-side pulse. Its value on every other cycle has no effect.
- R10: While reset is low, all four outputs are low.

Top module ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Synchronous active-low reset |
| force_ccm_i | input | 1 | Mode select: 1 forbids emulation, 0 allows it |
| pwm_req_i | input | 1 | PWM request from the modulator, 1 = high-side on |
| phase_pos_i | input | 1 | Switch-node polarity, 1 = positive |
| hs_en_o | output | 1 | High-side gate enable |
| ls_en_o | output | 1 | Low-side gate enable |
| dem_active_o | output | 1 | 1 while in diode emulation |
| clamp_req_o | output | 1 | One-cycle forced-pulse request from the audio clamp |

## Verification
The audio clamp can fire in the same cycle as the phase sample's decision, or as a mode-select change. A forced pulse then competes with a low-side kill or an exit from emulation. The bench provokes this by using a short clamp window and inserting idle stretches whose length lies near the limit, while phase polarity and mode select change at random. Every output is compared in every cycle against a bench model built from the requirements, so the collision is judged by the exact cycle in which each enable moves.

// File: rtl/dem_pkg.sv
// Shared types and helpers for the diode emulation controller.
// Assumes a single clock domain; all inputs already synchronous.
package dem_pkg;

    typedef enum logic {
        MODE_CCM = 1'b0,
        MODE_DEM = 1'b1
    } dem_mode_e;

    // Clock ticks in a window of per_us microseconds at clk_khz.
    function automatic int unsigned clamp_ticks(input int unsigned clk_khz,
                                                input int unsigned per_us);
        return (clk_khz * per_us) / 1000;
    endfunction

endpackage

// File: rtl/dem_gate_seq.sv
// Gate sequencer: turns the effective PWM request into high/low-side
// enables with a one-clock dead cycle at each hand-over.
// Assumes ls_block is held high whenever the low side must stay off.
module dem_gate_seq (
    input  logic clk,
    input  logic rst_n,
    input  logic pwm_eff,
    input  logic ls_block,
    output logic hs_en,
    output logic ls_en,
    output logic hs_next,
    output logic cyc_start
);
    logic ls_next;

    // Next-state of both enables; each waits for the other to be low.
    always_comb begin
        hs_next   = pwm_eff && !ls_en;
        ls_next   = !pwm_eff && !hs_en && !ls_block;
        cyc_start = hs_next && !hs_en;
    end

    // Enable registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hs_en <= 1'b0;
            ls_en <= 1'b0;
        end else begin
            hs_en <= hs_next;
            ls_en <= ls_next;
        end
    end
endmodule

// File: rtl/dem_phase_sampler.sv
// Phase sampler: raises a one-cycle strobe on the (SAMPLE_DLY+1)-th
// cycle of every low-side pulse, skipping turn-on ringing.
// Assumes ls_en is the registered low-side enable.
module dem_phase_sampler #(
    parameter int unsigned SAMPLE_DLY = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ls_en,
    output logic sample_stb
);
    generate
        if (SAMPLE_DLY == 0) begin : g_first
            logic ls_q;
            // Remember last cycle's low-side enable.
            always_ff @(posedge clk) begin
                if (!rst_n) ls_q <= 1'b0;
                else        ls_q <= ls_en;
            end
            assign sample_stb = ls_en && !ls_q;
        end else begin : g_count
            localparam int unsigned CW = $clog2(SAMPLE_DLY + 2);
            localparam logic [CW-1:0] AT_SAMPLE = CW'(SAMPLE_DLY);
            localparam logic [CW-1:0] SAT       = CW'(SAMPLE_DLY + 1);
            logic [CW-1:0] on_cnt;
            // Age of the current low-side pulse, saturating past the sample.
            always_ff @(posedge clk) begin
                if (!rst_n || !ls_en) on_cnt <= '0;
                else if (on_cnt != SAT) on_cnt <= on_cnt + 1'b1;
            end
            assign sample_stb = ls_en && (on_cnt == AT_SAMPLE);
        end
    endgenerate
endmodule

// File: rtl/dem_mode_fsm.sv
// Mode state machine: counts consecutive reverse-current samples to
// enter emulation, exits on forward current or forced mode, and blocks
// the low side once reverse current is seen while emulating.
// Assumes one sample strobe per low-side pulse at most.
module dem_mode_fsm
    import dem_pkg::*;
#(
    parameter int unsigned RUN_LEN = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic force_ccm,
    input  logic cyc_start,
    input  logic sample_stb,
    input  logic phase_pos,
    output logic dem_active,
    output logic ls_block
);
    localparam int unsigned RCW = $clog2(RUN_LEN);
    localparam logic [RCW-1:0] RUN_LAST = RCW'(RUN_LEN - 1);

    dem_mode_e      mode;
    logic [RCW-1:0] run_cnt;
    logic           ccm_latched;
    logic           blk;
    logic           kill;

    // Reverse current seen while emulating: cut the low side now.
    always_comb begin
        dem_active = (mode == MODE_DEM);
        kill       = dem_active && sample_stb && phase_pos;
        ls_block   = blk || kill;
    end

    // Mode select is latched at each new PWM cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)         ccm_latched <= 1'b1;
        else if (cyc_start) ccm_latched <= force_ccm;
    end

    // Consecutive positive-sample run counter.
    always_ff @(posedge clk) begin
        if (!rst_n || force_ccm || ccm_latched || dem_active)
            run_cnt <= '0;
        else if (sample_stb)
            run_cnt <= (phase_pos && run_cnt != RUN_LAST) ? run_cnt + 1'b1 : '0;
    end

    // Mode transitions.
    always_ff @(posedge clk) begin
        if (!rst_n || force_ccm)
            mode <= MODE_CCM;
        else if (dem_active && sample_stb && !phase_pos)
            mode <= MODE_CCM;
        else if (!dem_active && !ccm_latched && sample_stb && phase_pos
                 && run_cnt == RUN_LAST)
            mode <= MODE_DEM;
    end

    // Low-side block flag, held until the next PWM cycle.
    always_ff @(posedge clk) begin
        if (!rst_n || cyc_start || force_ccm) blk <= 1'b0;
        else if (kill)                        blk <= 1'b1;
    end
endmodule

// File: rtl/dem_audio_clamp.sv
// Audio clamp: counts clocks with the high side off and requests a
// forced pulse when the idle time reaches LIMIT, holding the request
// internally until the high side actually turns on.
// Assumes LIMIT >= 2.
module dem_audio_clamp #(
    parameter int unsigned LIMIT = 8750
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hs_en,
    input  logic hs_next,
    output logic clamp_req,
    output logic force_pend
);
    localparam int unsigned CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIM    = CW'(LIMIT);
    localparam logic [CW-1:0] LIM_M1 = CW'(LIMIT - 1);

    logic [CW-1:0] idle_cnt;

    // Idle clocks since the high side was last on, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n || hs_en)    idle_cnt <= '0;
        else if (idle_cnt != LIM) idle_cnt <= idle_cnt + 1'b1;
    end

    // One-cycle request when the idle window is used up.
    always_comb clamp_req = !hs_en && (idle_cnt == LIM_M1);

    // Keep the forced pulse pending across a dead cycle.
    always_ff @(posedge clk) begin
        if (!rst_n || hs_next) force_pend <= 1'b0;
        else if (clamp_req)    force_pend <= 1'b1;
    end
endmodule

// File: rtl/buck_dem_ctrl.sv
// Top of the diode emulation controller: merges the PWM request with
// the audio clamp, sequences the gates and runs the mode machine.
// Assumes synchronous inputs and CLK_KHZ * CLAMP_US >= 2000.
module buck_dem_ctrl
    import dem_pkg::*;
#(
    parameter int unsigned CLK_KHZ    = 250000,
    parameter int unsigned CLAMP_US   = 35,
    parameter int unsigned RUN_LEN    = 8,
    parameter int unsigned SAMPLE_DLY = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic force_ccm_i,
    input  logic pwm_req_i,
    input  logic phase_pos_i,
    output logic hs_en_o,
    output logic ls_en_o,
    output logic dem_active_o,
    output logic clamp_req_o
);
    localparam int unsigned CLAMP_LIMIT = clamp_ticks(CLK_KHZ, CLAMP_US);

    logic pwm_eff;
    logic force_pend;
    logic hs_next;
    logic cyc_start;
    logic ls_block;
    logic sample_stb;

    // Effective request: modulator or audio clamp.
    always_comb pwm_eff = pwm_req_i || force_pend || clamp_req_o;

    dem_gate_seq u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .pwm_eff  (pwm_eff),
        .ls_block (ls_block),
        .hs_en    (hs_en_o),
        .ls_en    (ls_en_o),
        .hs_next  (hs_next),
        .cyc_start(cyc_start)
    );

    dem_phase_sampler #(.SAMPLE_DLY(SAMPLE_DLY)) u_samp (
        .clk       (clk),
        .rst_n     (rst_n),
        .ls_en     (ls_en_o),
        .sample_stb(sample_stb)
    );

    dem_mode_fsm #(.RUN_LEN(RUN_LEN)) u_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .force_ccm (force_ccm_i),
        .cyc_start (cyc_start),
        .sample_stb(sample_stb),
        .phase_pos (phase_pos_i),
        .dem_active(dem_active_o),
        .ls_block  (ls_block)
    );

    dem_audio_clamp #(.LIMIT(CLAMP_LIMIT)) u_clamp (
        .clk       (clk),
        .rst_n     (rst_n),
        .hs_en     (hs_en_o),
        .hs_next   (hs_next),
        .clamp_req (clamp_req_o),
        .force_pend(force_pend)
    );
endmodule

// File: rtl/buck_dem_ctrl_chk.sv
// Property checker for buck_dem_ctrl, attached with bind.
module buck_dem_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic force_ccm_i,
    input logic phase_pos_i,
    input logic hs_en_o,
    input logic ls_en_o,
    input logic dem_active_o,
    input logic clamp_req_o,
    input logic pwm_eff,
    input logic sample_stb
);
    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_en_o && ls_en_o)); // R8
    AST_LS_AFTER_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ls_en_o) |-> !$past(hs_en_o)); // R8
    AST_HS_AFTER_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_en_o) |-> !$past(ls_en_o)); // R8
    AST_CCM_LS_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && !pwm_eff && !hs_en_o && !dem_active_o) |-> ls_en_o); // R1
    AST_ENTRY_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dem_active_o) |-> $past(sample_stb && phase_pos_i && !force_ccm_i)); // R2
    AST_DEM_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        dem_active_o && sample_stb && phase_pos_i |=> !ls_en_o); // R4
    AST_DEM_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        dem_active_o && sample_stb && !phase_pos_i |=> !dem_active_o); // R5
    AST_FORCE_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        force_ccm_i |=> !dem_active_o); // R7
    AST_CLAMP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        clamp_req_o |=> !clamp_req_o); // R6
    AST_ONE_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
        sample_stb |=> !sample_stb); // R9
endmodule

bind buck_dem_ctrl buck_dem_ctrl_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .force_ccm_i (force_ccm_i),
    .phase_pos_i (phase_pos_i),
    .hs_en_o     (hs_en_o),
    .ls_en_o     (ls_en_o),
    .dem_active_o(dem_active_o),
    .clamp_req_o (clamp_req_o),
    .pwm_eff     (pwm_eff),
    .sample_stb  (sample_stb)
);

// File: tb/tb_buck_dem_ctrl.sv
// Bench: directed corner cases plus seeded random pulses, all outputs
// compared each cycle with a model built from the requirements.
module tb_buck_dem_ctrl;
    localparam int CLK_KHZ = 250000;
    localparam int CLAMP_US = 2;
    localparam int RUN = 8;
    localparam int SD = 3;
    localparam int LIM = CLK_KHZ * CLAMP_US / 1000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic force_ccm = 1'b1, pwm_req = 1'b0, phase_pos = 1'b0;
    logic hs_en, ls_en, dem_active, clamp_req;

    int checks = 0, fails = 0, cyc = 0;
    int clamp_seen = 0, hs_rises = 0;

    // Model registers.
    logic m_hs, m_ls, m_dem, m_fq, m_blk, m_pend;
    int   m_run, m_scnt, m_idle;

    always #2 clk = ~clk;

    buck_dem_ctrl #(.CLK_KHZ(CLK_KHZ), .CLAMP_US(CLAMP_US), .RUN_LEN(RUN),
                    .SAMPLE_DLY(SD)) dut (
        .clk(clk), .rst_n(rst_n), .force_ccm_i(force_ccm), .pwm_req_i(pwm_req),
        .phase_pos_i(phase_pos), .hs_en_o(hs_en), .ls_en_o(ls_en),
        .dem_active_o(dem_active), .clamp_req_o(clamp_req));

    function automatic logic exp_clamp();
        return !m_hs && (m_idle == LIM - 1);
    endfunction

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 190000) begin
            fails = fails + 1;
            $display("FAIL R10 watchdog expired act=%0d exp<%0d", cyc, 190000);
            summary();
            $finish;
        end
    end

    task automatic chk(input string tag, input logic act, input logic exp);
        checks = checks + 1;
        if (act !== exp) begin
            fails = fails + 1;
            $display("FAIL %s act=%0b exp=%0b t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_hs = 0; m_ls = 0; m_dem = 0; m_fq = 1; m_blk = 0; m_pend = 0;
        m_run = 0; m_scnt = 0; m_idle = 0;
    endtask

    // Next state of the model for the inputs applied this cycle.
    task automatic model_step(input logic f, input logic p, input logic ph);
        logic clmp, eff, stb, kill, cst, hs_n, ls_n, dem_n, fq_n, blk_n, pend_n;
        int run_n, scnt_n, idle_n;
        clmp = exp_clamp();
        eff  = p || m_pend || clmp;
        stb  = m_ls && (m_scnt == SD);
        kill = m_dem && stb && ph;
        hs_n = eff && !m_ls;
        cst  = hs_n && !m_hs;
        ls_n = !eff && !m_hs && !(m_blk || kill);
        if (f) dem_n = 0;
        else if (m_dem && stb && !ph) dem_n = 0;
        else if (!m_dem && !m_fq && stb && ph && m_run == RUN - 1) dem_n = 1;
        else dem_n = m_dem;
        if (f || m_fq || m_dem) run_n = 0;
        else if (stb) run_n = (ph && m_run != RUN - 1) ? m_run + 1 : 0;
        else run_n = m_run;
        fq_n   = cst ? f : m_fq;
        blk_n  = (cst || f) ? 1'b0 : (kill ? 1'b1 : m_blk);
        scnt_n = !m_ls ? 0 : ((m_scnt == SD + 1) ? m_scnt : m_scnt + 1);
        idle_n = m_hs ? 0 : ((m_idle == LIM) ? m_idle : m_idle + 1);
        pend_n = hs_n ? 1'b0 : (clmp ? 1'b1 : m_pend);
        m_hs = hs_n; m_ls = ls_n; m_dem = dem_n; m_run = run_n; m_fq = fq_n;
        m_blk = blk_n; m_scnt = scnt_n; m_idle = idle_n; m_pend = pend_n;
    endtask

    // One cycle: drive at negedge, step the model, compare at next negedge.
    task automatic tick(input logic f, input logic p, input logic ph);
        logic prev_hs;
        force_ccm = f; pwm_req = p; phase_pos = ph;
        prev_hs = hs_en;
        model_step(f, p, ph);
        @(negedge clk);
        if (clamp_req) clamp_seen = clamp_seen + 1;
        if (hs_en && !prev_hs) hs_rises = hs_rises + 1;
        chk("R8 hs_en", hs_en, m_hs);
        chk("R1 ls_en", ls_en, m_ls);
        chk("R2 dem_active", dem_active, m_dem);
        chk("R6 clamp_req", clamp_req, exp_clamp());
        chk("R8 overlap", hs_en && ls_en, 1'b0);
    endtask

    task automatic pulse(input logic f, input int on_l, input int off_l,
                         input logic ph_on, input logic ph_off);
        for (int i = 0; i < on_l; i++) tick(f, 1'b1, ph_on);
        for (int i = 0; i < off_l; i++) tick(f, 1'b0, ph_off);
    endtask

    initial begin
        void'($urandom(32'd1234));
        model_reset();
        repeat (4) @(negedge clk);
        chk("R10 hs_en reset", hs_en, 1'b0);
        chk("R10 ls_en reset", ls_en, 1'b0);
        chk("R10 dem_active reset", dem_active, 1'b0);
        chk("R10 clamp_req reset", clamp_req, 1'b0);
        rst_n = 1'b1;

        // R1: forced mode, low side fills the off-time.
        pulse(1'b1, 3, 6, 1'b1, 1'b1);
        chk("R1 ls on in forced mode", ls_en, 1'b1);
        chk("R7 no emulation when forced", dem_active, 1'b0);

        // R2: seven positive pulses are not enough, the eighth enters.
        for (int k = 0; k < RUN - 1; k++) pulse(1'b0, 3, 10, 1'b0, 1'b1);
        chk("R2 no entry after seven", dem_active, 1'b0);
        pulse(1'b0, 3, 10, 1'b0, 1'b1);
        chk("R2 entry after eight", dem_active, 1'b1);

        // R7: forcing high exits at once.
        tick(1'b1, 1'b0, 1'b1);
        chk("R7 forced exit", dem_active, 1'b0);

        // R3: a negative sample restarts the run.
        for (int k = 0; k < 5; k++) pulse(1'b0, 3, 10, 1'b0, 1'b1);
        pulse(1'b0, 3, 10, 1'b1, 1'b0);
        for (int k = 0; k < RUN - 1; k++) pulse(1'b0, 3, 10, 1'b0, 1'b1);
        chk("R3 run restarted", dem_active, 1'b0);
        pulse(1'b0, 3, 10, 1'b0, 1'b1);
        chk("R3 entry after full run", dem_active, 1'b1);

        // R4: reverse current in emulation turns the low side off.
        pulse(1'b0, 3, 10, 1'b1, 1'b1);
        chk("R4 ls blocked", ls_en, 1'b0);
        chk("R4 still emulating", dem_active, 1'b1);

        // R9: negative phase outside the sample slot is ignored.
        pulse(1'b0, 3, 10, 1'b0, 1'b1);
        chk("R9 off-slot phase ignored", dem_active, 1'b1);

        // R5: forward current returns to continuous conduction.
        pulse(1'b0, 3, 10, 1'b1, 1'b0);
        chk("R5 exit on forward current", dem_active, 1'b0);

        // R6: long idle triggers a single forced pulse.
        clamp_seen = 0; hs_rises = 0;
        for (int k = 0; k < LIM + 4; k++) tick(1'b0, 1'b0, 1'b0);
        chk("R6 one clamp request", clamp_seen == 1, 1'b1);
        chk("R6 forced high-side pulse", hs_rises == 1, 1'b1);

        // Random mix around the clamp window and mode changes.
        begin
            logic fr;
            int prob;
            fr = 1'b0;
            prob = 90;
            for (int i = 0; i < 2500; i++) begin
                int on_l, off_l;
                on_l  = 1 + $urandom_range(5);
                off_l = 1 + $urandom_range(13);
                if ($urandom_range(99) < 3) fr = ~fr;
                if (i % 40 == 0) prob = $urandom_range(100);
                for (int c = 0; c < on_l; c++) tick(fr, 1'b1, $urandom_range(99) < prob);
                for (int c = 0; c < off_l; c++) tick(fr, 1'b0, $urandom_range(99) < prob);
                if ($urandom_range(99) < 2) begin
                    int idle_l;
                    idle_l = LIM - 3 + $urandom_range(6);
                    for (int c = 0; c < idle_l; c++)
                        tick(fr, 1'b0, $urandom_range(99) < prob);
                end
            end
        end

        summary();
        $finish;
    end
endmodule